// File: doc/BRIEF.md
# Multi-Rail Power-Up Sequencer

This block orders the start of four supply rails on a board: a bus termination rail, a graphics bus rail, a switching core rail and an always-on chipset rail. Three supply-ready flags stand for the power-on monitors. Once all three are up, the block runs two soft-start ramps. Each ramp is a digital code that stands in for a charging capacitor, with full scale 1000 meaning about 4.5 V. The first ramp drives the bus rail. The second ramp stays at zero until the bus rail passes its 90% level. It then drives the core and graphics references.

The block reads comparator flags for each rail and a strobe that marks each switching pulse of the core converter. From these it produces two good outputs. The early bus-good flag waits for the first switching pulse once the core rail is allowed to switch. The system good flag reports that every rail is in its proper range. A shutdown input pulls the first ramp to zero, which turns off the three sequenced rails. The chipset rail stays on but falls back to an intermediate level. A separate fault manager reads the "up" flags that mark a fully charged ramp.

Top module: `pwr_rail_seq`

## Requirements
- R1: A synchronous active-high reset sets both ramp codes to 0 and drives every output low, en_chip included.
- R2: Both ramps hold code 0 while any of bias_ok, main_ok or aux_ok is low. If one of them drops, both codes are 0 after the next clock edge.
- R3: ramp_a moves on each clock edge once all supplies are ready and shut_req is low. From 0 it jumps to 250. After that it adds step_cfg on each edge and stops at 1000.
- R4: ramp_b is forced to 0 whenever ramp_a is at or below 177. Otherwise it stays at 0 until rail2_ok is sampled high. After that it adds step_cfg on each edge, starting from 0 and stopping at 1000.
- R5: en_bus and en_gfx are high exactly when ramp_a > 177. en_core is high exactly when ramp_a > 177 and ramp_b > 277.
- R6: bus_good rises on the edge after an sw_pulse that is sampled while en_core and rail2_ok are both high. A pulse at any other time has no effect. bus_good falls in the same cycle that rail2_ok or en_core falls.
- R7: sys_good rises one edge after en_core, core_inwin, rail2_ok, rail3_ok and rail4_ok are all high together. It falls in the same cycle that any of them falls.
- R8: shut_req high forces both ramp codes to 0 on the next edge. This also clears en_bus, en_gfx and en_core.
- R9: up_a is high exactly when ramp_a > 888, and up_b is high exactly when ramp_b > 888.
- R10: en_chip goes high on the first edge after reset and stays high whatever the supply flags or shut_req do. chip_full is high exactly when ramp_a > 177; otherwise the chipset rail sits at its intermediate level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bias_ok | input | 1 | Bias supply above its reset threshold |
| main_ok | input | 1 | Main input supply above its reset threshold |
| aux_ok | input | 1 | Auxiliary supply above its reset threshold |
| shut_req | input | 1 | External request to hold the first ramp low |
| step_cfg | input | 8 | Ramp increment per cycle |
| rail2_ok | input | 1 | Bus rail above its undervoltage (90%) level |
| rail3_ok | input | 1 | Graphics rail above its undervoltage level |
| rail4_ok | input | 1 | Chipset rail above its undervoltage level |
| core_inwin | input | 1 | Core rail inside its ±10% window |
| sw_pulse | input | 1 | Strobe for one switching pulse of the core converter |
| en_bus | output | 1 | Bus rail enable |
| en_gfx | output | 1 | Graphics rail enable |
| en_core | output | 1 | Core switcher enable |
| en_chip | output | 1 | Chipset rail enable |
| chip_full | output | 1 | Chipset rail at full level (low means intermediate level) |
| ramp_a | output | 10 | First soft-start code |
| ramp_b | output | 10 | Second soft-start code |
| up_a | output | 1 | First ramp fully charged |
| up_b | output | 1 | Second ramp fully charged |
| bus_good | output | 1 | Early bus-rail good |
| sys_good | output | 1 | System power good |

## Verification
Each ramp code leaves its register and reaches a port with no logic in between. A wrong code therefore shows on ramp_a or ramp_b at the first edge after the fault, and the enables and up flags derived from it change in that same cycle. If a good flag's latched state is wrong, the error first shows when its qualifying condition holds. A stale latch makes the flag rise with no pulse, or makes it stay low after a pulse has arrived. The same-cycle deassert is checked in the middle of the cycle, right after inputs change and before the next edge.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    localparam int RAMP_W_DEF   = 10;
    localparam int RAMP_MAX_DEF = 1000;
    localparam int STEP_W_DEF   = 8;

    // Ramp levels as fractions of full scale (full scale ~ 4.5 V)
    function automatic int low_level(input int fs);      // ~0.8 V
        return (fs * 8) / 45;
    endfunction

    function automatic int valley_level(input int fs);   // ~1.25 V
        return (fs * 5) / 18;
    endfunction

    function automatic int up_level(input int fs);       // ~4.0 V
        return (fs * 8) / 9;
    endfunction

    function automatic int jump_level(input int fs);     // quick first jump
        return fs / 4;
    endfunction

    typedef enum logic [1:0] {
        PH_ZERO  = 2'd0,
        PH_CLIMB = 2'd1,
        PH_FULL  = 2'd2
    } ramp_phase_t;

    typedef struct packed {
        logic bus;
        logic gfx;
        logic core;
    } rail_en_t;

    typedef struct packed {
        logic clear;
        logic go;
    } ramp_ctl_t;

endpackage

// File: rtl/pseq_ramp.sv
module pseq_ramp
    import pseq_pkg::*;
#(
    parameter int RW   = RAMP_W_DEF,
    parameter int MAX  = RAMP_MAX_DEF,
    parameter int SW   = STEP_W_DEF,
    parameter int JUMP = 0,
    parameter int UP   = 888
) (
    input  logic          clk,
    input  logic          rst,
    input  ramp_ctl_t     ctl,
    input  logic [SW-1:0] step,
    output logic [RW-1:0] code,
    output logic          up
);

    localparam logic [RW:0]   MAX_X = (RW+1)'(MAX);
    localparam logic [RW-1:0] MAX_C = RW'(MAX);
    localparam logic [RW-1:0] UP_C  = RW'(UP);

    logic [RW-1:0] code_q;
    logic [RW-1:0] code_d;
    logic [RW-1:0] sat_v;
    logic [RW-1:0] start_v;
    logic [RW:0]   sum;
    ramp_phase_t   phase;

    // saturating increment
    always_comb begin
        sum   = {1'b0, code_q} + {{(RW+1-SW){1'b0}}, step};
        sat_v = (sum > MAX_X) ? MAX_C : sum[RW-1:0];
    end

    // variant: quick jump on the first step, or a plain climb from zero
    generate
        if (JUMP > 0) begin : g_jump
            assign start_v = RW'(JUMP);
        end else begin : g_plain
            assign start_v = sat_v;
        end
    endgenerate

    always_comb begin
        if (code_q == '0)
            phase = PH_ZERO;
        else if (code_q == MAX_C)
            phase = PH_FULL;
        else
            phase = PH_CLIMB;
    end

    always_comb begin
        code_d = code_q;
        if (ctl.clear) begin
            code_d = '0;
        end else begin
            case (phase)
                PH_ZERO:  code_d = ctl.go ? start_v : '0;
                PH_CLIMB: code_d = sat_v;
                PH_FULL:  code_d = MAX_C;
                default:  code_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else
            code_q <= code_d;
    end

    assign code = code_q;
    assign up   = (code_q > UP_C);

    AST_RAMP_LIMIT: assert property (@(posedge clk) disable iff (rst)
        code_q <= MAX_C);                                        // R3
    AST_RAMP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ctl.clear |=> (code_q == '0));                           // R2
    AST_RAMP_MONO: assert property (@(posedge clk) disable iff (rst)
        !ctl.clear |=> (code_q >= $past(code_q)));               // R3

endmodule

// File: rtl/pseq_goodflag.sv
module pseq_goodflag (
    input  logic clk,
    input  logic rst,
    input  logic qual,
    input  logic arm,
    output logic good
);

    logic held_q;

    // latched once armed while qualified; dropped as soon as qualification fails
    always_ff @(posedge clk) begin
        if (rst)
            held_q <= 1'b0;
        else
            held_q <= qual & (held_q | arm);
    end

    assign good = held_q & qual;

endmodule

// File: rtl/pwr_rail_seq.sv
module pwr_rail_seq
    import pseq_pkg::*;
#(
    parameter int RAMP_W   = RAMP_W_DEF,
    parameter int RAMP_MAX = RAMP_MAX_DEF,
    parameter int STEP_W   = STEP_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bias_ok,
    input  logic              main_ok,
    input  logic              aux_ok,
    input  logic              shut_req,
    input  logic [STEP_W-1:0] step_cfg,
    input  logic              rail2_ok,
    input  logic              rail3_ok,
    input  logic              rail4_ok,
    input  logic              core_inwin,
    input  logic              sw_pulse,
    output logic              en_bus,
    output logic              en_gfx,
    output logic              en_core,
    output logic              en_chip,
    output logic              chip_full,
    output logic [RAMP_W-1:0] ramp_a,
    output logic [RAMP_W-1:0] ramp_b,
    output logic              up_a,
    output logic              up_b,
    output logic              bus_good,
    output logic              sys_good
);

    localparam int LOW_T = low_level(RAMP_MAX);
    localparam int VAL_T = valley_level(RAMP_MAX);
    localparam int UP_T  = up_level(RAMP_MAX);
    localparam int JMP_T = jump_level(RAMP_MAX);
    localparam logic [RAMP_W-1:0] LOW_C = RAMP_W'(LOW_T);
    localparam logic [RAMP_W-1:0] VAL_C = RAMP_W'(VAL_T);
    localparam int NGOOD = 2;

    logic      supplies_ok;
    logic      rails_on;
    ramp_ctl_t ctl_a;
    ramp_ctl_t ctl_b;
    rail_en_t  rail_en;
    logic      bus_qual;
    logic      sys_qual;
    logic      chip_q;
    logic [NGOOD-1:0] g_qual;
    logic [NGOOD-1:0] g_arm;
    logic [NGOOD-1:0] g_out;

    assign supplies_ok = bias_ok & main_ok & aux_ok;
    assign rails_on    = (ramp_a > LOW_C);

    always_comb begin
        ctl_a.clear = ~supplies_ok | shut_req;
        ctl_a.go    = 1'b1;
        ctl_b.clear = ctl_a.clear | ~rails_on;
        ctl_b.go    = rail2_ok;
    end

    pseq_ramp #(
        .RW(RAMP_W), .MAX(RAMP_MAX), .SW(STEP_W), .JUMP(JMP_T), .UP(UP_T)
    ) u_ramp_a (
        .clk(clk), .rst(rst), .ctl(ctl_a), .step(step_cfg),
        .code(ramp_a), .up(up_a)
    );

    pseq_ramp #(
        .RW(RAMP_W), .MAX(RAMP_MAX), .SW(STEP_W), .JUMP(0), .UP(UP_T)
    ) u_ramp_b (
        .clk(clk), .rst(rst), .ctl(ctl_b), .step(step_cfg),
        .code(ramp_b), .up(up_b)
    );

    always_comb begin
        rail_en.bus  = rails_on;
        rail_en.gfx  = rails_on;
        rail_en.core = rails_on & (ramp_b > VAL_C);
    end

    assign en_bus  = rail_en.bus;
    assign en_gfx  = rail_en.gfx;
    assign en_core = rail_en.core;

    assign bus_qual = rail_en.core & rail2_ok;
    assign sys_qual = rail_en.core & core_inwin & rail2_ok & rail3_ok & rail4_ok;

    // index 0: early bus good (armed by a switching pulse), 1: system good
    assign g_qual = {sys_qual, bus_qual};
    assign g_arm  = {1'b1, sw_pulse};

    generate
        for (genvar gi = 0; gi < NGOOD; gi++) begin : g_good
            pseq_goodflag u_flag (
                .clk(clk), .rst(rst),
                .qual(g_qual[gi]), .arm(g_arm[gi]),
                .good(g_out[gi])
            );
        end
    endgenerate

    assign bus_good = g_out[0];
    assign sys_good = g_out[1];

    // chipset rail: enabled apart from the supply monitors
    always_ff @(posedge clk) begin
        if (rst)
            chip_q <= 1'b0;
        else
            chip_q <= 1'b1;
    end

    assign en_chip   = chip_q;
    assign chip_full = rails_on;

    AST_B_WAITS_BUS: assert property (@(posedge clk) disable iff (rst)
        (ramp_b != '0 && $past(ramp_b) == '0) |-> $past(rail2_ok));   // R4
    AST_BUS_GOOD_PULSE: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_good) |-> $past(sw_pulse));                        // R6
    AST_SYS_GOOD_QUAL: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_good) |-> $past(sys_qual));                        // R7
    AST_SHUT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        shut_req |=> (ramp_a == '0 && ramp_b == '0 && !en_core));     // R8
    AST_CHIP_STAYS: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> en_chip);                                    // R10

endmodule

// File: tb/pwr_rail_seq_tb.sv
`timescale 1ns/1ps
module pwr_rail_seq_tb;

    localparam int MAXV = 1000;
    localparam int LOWV = 177;
    localparam int VALV = 277;
    localparam int UPV  = 888;
    localparam int JMPV = 250;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, bias_ok, main_ok, aux_ok, shut_req;
    logic [7:0] step_cfg;
    logic rail2_ok, rail3_ok, rail4_ok, core_inwin, sw_pulse;
    logic en_bus, en_gfx, en_core, en_chip, chip_full, up_a, up_b, bus_good, sys_good;
    logic [9:0] ramp_a, ramp_b;

    pwr_rail_seq u_dut (
        .clk(clk), .rst(rst), .bias_ok(bias_ok), .main_ok(main_ok), .aux_ok(aux_ok),
        .shut_req(shut_req), .step_cfg(step_cfg), .rail2_ok(rail2_ok),
        .rail3_ok(rail3_ok), .rail4_ok(rail4_ok), .core_inwin(core_inwin),
        .sw_pulse(sw_pulse), .en_bus(en_bus), .en_gfx(en_gfx), .en_core(en_core),
        .en_chip(en_chip), .chip_full(chip_full), .ramp_a(ramp_a), .ramp_b(ramp_b),
        .up_a(up_a), .up_b(up_b), .bus_good(bus_good), .sys_good(sys_good)
    );

    // staging inputs, applied at the falling edge
    bit s_rst, s_bias, s_main, s_aux, s_shut, s_r2, s_r3, s_r4, s_win, s_pulse;
    int s_step;

    // reference model state
    int ma, mb;
    bit mqb, mqs, mchip;

    typedef struct packed {
        int ra;
        int rb;
        bit eb, eg, ec, ech, cf, ua, ub, bg, sg;
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];
    exp_t  cur;
    string cur_tag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit m_core(input int a, input int b);
        return (a > LOWV) && (b > VALV);
    endfunction

    function automatic int sat_add(input int v, input int s);
        return (v + s > MAXV) ? MAXV : v + s;
    endfunction

    // driver: applies inputs, advances the model, pushes the expected result
    task automatic cyc(input string tag);
        bit all_ok, bq, sq, nqb;
        int na, nb;
        exp_t e;
        @(negedge clk);
        rst = s_rst; bias_ok = s_bias; main_ok = s_main; aux_ok = s_aux;
        shut_req = s_shut; step_cfg = 8'(s_step); rail2_ok = s_r2; rail3_ok = s_r3;
        rail4_ok = s_r4; core_inwin = s_win; sw_pulse = s_pulse;
        #1;
        // same-cycle deassert of the good flags
        check("R6", {tag, " bus_good mid-cycle"}, int'(bus_good),
              int'(mqb && m_core(ma, mb) && s_r2));
        check("R7", {tag, " sys_good mid-cycle"}, int'(sys_good),
              int'(mqs && m_core(ma, mb) && s_r2 && s_r3 && s_r4 && s_win));
        if (s_rst) begin
            ma = 0; mb = 0; mqb = 0; mqs = 0; mchip = 0;
        end else begin
            all_ok = s_bias && s_main && s_aux;
            bq  = m_core(ma, mb) && s_r2;
            sq  = bq && s_r3 && s_r4 && s_win;
            nqb = bq && (mqb || s_pulse);
            if (!all_ok || s_shut) na = 0;
            else if (ma == 0) na = JMPV;
            else na = sat_add(ma, s_step);
            if (!all_ok || s_shut || ma <= LOWV) nb = 0;
            else if (mb != 0 || s_r2) nb = sat_add(mb, s_step);
            else nb = 0;
            ma = na; mb = nb; mqb = nqb; mqs = sq; mchip = 1;
        end
        e.ra  = ma;
        e.rb  = mb;
        e.eb  = (ma > LOWV);
        e.eg  = (ma > LOWV);
        e.ec  = m_core(ma, mb);
        e.ech = mchip;
        e.cf  = (ma > LOWV);
        e.ua  = (ma > UPV);
        e.ub  = (mb > UPV);
        e.bg  = mqb && m_core(ma, mb) && s_r2;
        e.sg  = mqs && m_core(ma, mb) && s_r2 && s_r3 && s_r4 && s_win;
        sb_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compares each produced result with the queued expectation
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            cur     = sb_q.pop_front();
            cur_tag = tag_q.pop_front();
            check("R3", {cur_tag, " ramp_a"},    int'(ramp_a),    cur.ra);
            check("R4", {cur_tag, " ramp_b"},    int'(ramp_b),    cur.rb);
            check("R5", {cur_tag, " en_bus"},    int'(en_bus),    int'(cur.eb));
            check("R5", {cur_tag, " en_gfx"},    int'(en_gfx),    int'(cur.eg));
            check("R5", {cur_tag, " en_core"},   int'(en_core),   int'(cur.ec));
            check("R10", {cur_tag, " en_chip"},  int'(en_chip),   int'(cur.ech));
            check("R10", {cur_tag, " chip_full"}, int'(chip_full), int'(cur.cf));
            check("R9", {cur_tag, " up_a"},      int'(up_a),      int'(cur.ua));
            check("R9", {cur_tag, " up_b"},      int'(up_b),      int'(cur.ub));
            check("R6", {cur_tag, " bus_good"},  int'(bus_good),  int'(cur.bg));
            check("R7", {cur_tag, " sys_good"},  int'(sys_good),  int'(cur.sg));
        end
    end

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_up();
        end
    end

    initial begin
        rst = 1'b1; bias_ok = 0; main_ok = 0; aux_ok = 0; shut_req = 0; step_cfg = 8'd40;
        rail2_ok = 0; rail3_ok = 0; rail4_ok = 0; core_inwin = 0; sw_pulse = 0;
        ma = 0; mb = 0; mqb = 0; mqs = 0; mchip = 0;
        s_rst = 1; s_step = 40;

        repeat (3) cyc("R1 reset");

        s_rst = 0; s_bias = 1; s_main = 1; s_aux = 0;
        repeat (4) cyc("R2 aux missing, R10 chipset on");

        s_aux = 1;
        for (int i = 0; i < 25; i++) begin
            s_pulse = (i % 3 == 0);
            cyc("R3 climb with bus low, R6 early pulses ignored");
        end

        s_r2 = 1; s_pulse = 0;
        for (int i = 0; i < 16; i++) begin
            s_pulse = (i == 9);
            cyc("R4 second ramp, R6 first pulse");
        end

        s_r3 = 1; s_r4 = 1; s_win = 1;
        repeat (20) cyc("R7 all rails good, R9 full");

        s_r3 = 0;
        repeat (2) cyc("R7 graphics rail drop");
        s_r3 = 1;
        repeat (2) cyc("R7 graphics rail back");

        s_r2 = 0;
        repeat (2) cyc("R6 bus rail drop");
        s_r2 = 1;
        repeat (2) cyc("R6 no pulse after return");
        s_pulse = 1;
        cyc("R6 re-arm pulse");
        s_pulse = 0;
        repeat (2) cyc("R6 re-armed");

        s_shut = 1;
        repeat (3) cyc("R8 shutdown held");
        s_shut = 0; s_step = 7;
        repeat (30) cyc("R3 restart with odd step");

        s_main = 0;
        repeat (3) cyc("R2 main supply drop");
        s_main = 1;
        repeat (3) cyc("R2 main supply back");

        s_rst = 1;
        repeat (2) cyc("R1 reset again");

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        finish_up();
    end

endmodule